// File: doc/BRIEF.md
# Serial LCD Frame Shifter

This block turns one request for a display controller (a single instruction or data byte, an address pair, or a run of graphics data) into the serial frame such controllers accept on a three-wire synchronous link. Every frame begins with a header byte. The header carries a fixed run of ones, a direction bit and a register-select bit. Each payload byte follows as two wire bytes. Each wire byte carries one nibble in its upper half and zeros in its lower half. Bits leave most significant first on a divided serial clock. Chip select stays high from just before the first bit until just after the last.

A host pulses `start` together with a mode, the direction and select flags, and a payload vector. The block takes the request, raises `busy`, shifts the frame and then drops `busy` with a one-cycle `done` pulse. While a frame is in flight, further start pulses are dropped. The serial clock half-period and the burst length are parameters.

Top module: `lcd_serial_framer`

## Requirements
- R1: The header byte is 8'b11111_W_S_0, where W is the direction bit (weight 0x04) and S is the register-select bit (weight 0x02). In single mode (`mode`=0) W and S come from `rw` and `rs`.
- R2: Payload byte b is sent as {b[7:4],4'b0000} and then as {b[3:0],4'b0000}. Payload byte j is `payload[8j+7:8j]`, and bytes are taken in rising j.
- R3: Single mode (`mode`=0) sends header, then payload byte 0: 3 wire bytes.
- R4: Address mode (`mode`=1) sends header 0xF8 (W=0, S=0), then payload bytes 0 and 1: 5 wire bytes.
- R5: Burst mode (`mode`=2) sends header 0xFA (W=0, S=1), then payload bytes 0 to BURST_BYTES-1: 1+2*BURST_BYTES wire bytes.
- R6: Bits leave MSB first. `sdo` is valid through each rising edge of `sclk`. `sclk` idles low, and each half period lasts HALF_DIV clock cycles.
- R7: `cs` rises in the cycle after an accepted start. It is high for one half period before the first rising `sclk` edge and for one half period after the last falling edge.
- R8: `busy` is high for exactly HALF_DIV*(16*W+1) cycles for a frame of W wire bytes. `done` is a single-cycle pulse in the cycle `busy` falls.
- R9: A start pulse while `busy` is high is ignored: the frame in flight is unchanged and no second frame follows.
- R10: A start with `mode`=3 is ignored: no `busy`, no `cs`, no `sclk` activity.
- R11: After reset `cs`, `sclk`, `sdo`, `busy` and `done` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse |
| mode | input | 2 | 0 single, 1 address pair, 2 burst, 3 reserved |
| rw | input | 1 | Direction bit for single mode |
| rs | input | 1 | Register-select bit for single mode |
| payload | input | 8*BURST_BYTES | Payload bytes, byte 0 in the low bits |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| cs | output | 1 | Chip select, active high |
| sclk | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |

## Verification
The hardest case to reach is a start request that lands in the middle of a frame. The stimulus launches a short single-byte frame and then, partway through the bit stream, pulses start again with burst mode and different data. The captured frame must still be the original three bytes, and chip select must stay low after `done`. The reserved mode is driven from idle in the same way, to show that it never opens a frame.

// File: rtl/lcd_frm_pkg.sv
package lcd_frm_pkg;

   typedef enum logic [1:0] {
      FM_SINGLE = 2'd0,
      FM_ADDR   = 2'd1,
      FM_BURST  = 2'd2,
      FM_RSVD   = 2'd3
   } frm_mode_e;

   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_LEAD  = 2'd1,
      SQ_SHIFT = 2'd2,
      SQ_TAIL  = 2'd3
   } seq_state_e;

   localparam logic [7:0] HDR_BASE = 8'hF8;

   function automatic logic [7:0] make_hdr(input logic dir_b, input logic sel_b);
      return HDR_BASE | {5'b0, dir_b, sel_b, 1'b0};
   endfunction

endpackage

// File: rtl/lcd_half_tick.sv
module lcd_half_tick #(
   parameter int HALF_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic tick
);
   generate
      if (HALF_DIV == 1) begin : g_direct
         assign tick = en;
      end else begin : g_count
         localparam int CW = $clog2(HALF_DIV);
         localparam logic [CW-1:0] TOP = CW'(HALF_DIV - 1);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)               cnt <= '0;
            else if (!en || tick)     cnt <= '0;
            else                      cnt <= cnt + 1'b1;
         end
         assign tick = en && (cnt == TOP);
      end
   endgenerate
endmodule

// File: rtl/lcd_wire_mux.sv
module lcd_wire_mux #(
   parameter int BURST_BYTES = 16,
   parameter int MAXW        = 1 + 2 * BURST_BYTES,
   parameter int IDXW        = $clog2(MAXW)
) (
   input  logic [7:0]               hdr,
   input  logic [8*BURST_BYTES-1:0] pay,
   input  logic [IDXW-1:0]          idx,
   output logic [7:0]               wbyte
);
   logic [7:0] wires [MAXW];

   assign wires[0] = hdr;

   generate
      for (genvar j = 0; j < BURST_BYTES; j++) begin : g_split
         assign wires[1 + 2*j] = {pay[8*j+7 -: 4], 4'b0000};
         assign wires[2 + 2*j] = {pay[8*j+3 -: 4], 4'b0000};
      end
   endgenerate

   always_comb begin
      wbyte = 8'h00;
      for (int k = 0; k < MAXW; k++)
         if (idx == IDXW'(k)) wbyte = wires[k];
   end
endmodule

// File: rtl/lcd_frame_seq.sv
module lcd_frame_seq
   import lcd_frm_pkg::*;
#(
   parameter int IDXW = 6
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            launch,
   input  logic            tick,
   input  logic [IDXW-1:0] last_idx,
   input  logic [7:0]      cur_byte,
   output logic [IDXW-1:0] idx,
   output logic            active,
   output logic            sclk,
   output logic            sdo,
   output logic            done
);
   seq_state_e st;
   logic [2:0] bitn;
   logic       ph;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= SQ_IDLE;
         idx  <= '0;
         bitn <= '0;
         ph   <= 1'b0;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (st)
            SQ_IDLE: if (launch) begin
               st   <= SQ_LEAD;
               idx  <= '0;
               bitn <= '0;
               ph   <= 1'b0;
            end
            SQ_LEAD: if (tick) begin
               st <= SQ_SHIFT;
               ph <= 1'b1;
            end
            SQ_SHIFT: if (tick) begin
               if (!ph) begin
                  ph <= 1'b1;
               end else if (bitn == 3'd7 && idx == last_idx) begin
                  st <= SQ_TAIL;
                  ph <= 1'b0;
               end else begin
                  ph <= 1'b0;
                  if (bitn == 3'd7) begin
                     bitn <= '0;
                     idx  <= idx + 1'b1;
                  end else begin
                     bitn <= bitn + 1'b1;
                  end
               end
            end
            SQ_TAIL: if (tick) begin
               st   <= SQ_IDLE;
               done <= 1'b1;
            end
            default: st <= SQ_IDLE;
         endcase
      end
   end

   assign active = (st != SQ_IDLE);
   assign sclk   = (st == SQ_SHIFT) && ph;
   assign sdo    = (st == SQ_LEAD || st == SQ_SHIFT) ? cur_byte[3'd7 - bitn] : 1'b0;
endmodule

// File: rtl/lcd_serial_framer.sv
module lcd_serial_framer
   import lcd_frm_pkg::*;
#(
   parameter int HALF_DIV    = 4,
   parameter int BURST_BYTES = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start,
   input  logic [1:0]               mode,
   input  logic                     rw,
   input  logic                     rs,
   input  logic [8*BURST_BYTES-1:0] payload,
   output logic                     busy,
   output logic                     done,
   output logic                     cs,
   output logic                     sclk,
   output logic                     sdo
);
   localparam int MAXW = 1 + 2 * BURST_BYTES;
   localparam int IDXW = $clog2(MAXW);
   localparam int PW   = 8 * BURST_BYTES;

   generate
      if (HALF_DIV < 1) begin : g_bad_div
         $error("HALF_DIV must be at least 1");
      end
      if (BURST_BYTES < 2) begin : g_bad_burst
         $error("BURST_BYTES must be at least 2");
      end
   endgenerate

   logic            active, tick, launch;
   logic [IDXW-1:0] idx, last_q;
   logic [7:0]      hdr_q, cur_byte;
   logic [PW-1:0]   pay_q;

   assign launch = start && !active && (frm_mode_e'(mode) != FM_RSVD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hdr_q  <= '0;
         pay_q  <= '0;
         last_q <= '0;
      end else if (launch) begin
         pay_q <= payload;
         unique case (frm_mode_e'(mode))
            FM_SINGLE: begin
               hdr_q  <= make_hdr(rw, rs);
               last_q <= IDXW'(2);
            end
            FM_ADDR: begin
               hdr_q  <= make_hdr(1'b0, 1'b0);
               last_q <= IDXW'(4);
            end
            default: begin
               hdr_q  <= make_hdr(1'b0, 1'b1);
               last_q <= IDXW'(MAXW - 1);
            end
         endcase
      end
   end

   lcd_half_tick #(.HALF_DIV(HALF_DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .en(active), .tick(tick)
   );

   lcd_wire_mux #(.BURST_BYTES(BURST_BYTES), .MAXW(MAXW), .IDXW(IDXW)) u_mux (
      .hdr(hdr_q), .pay(pay_q), .idx(idx), .wbyte(cur_byte)
   );

   lcd_frame_seq #(.IDXW(IDXW)) u_seq (
      .clk(clk), .rst_n(rst_n), .launch(launch), .tick(tick),
      .last_idx(last_q), .cur_byte(cur_byte), .idx(idx),
      .active(active), .sclk(sclk), .sdo(sdo), .done(done)
   );

   assign busy = active;
   assign cs   = active;
endmodule

// File: rtl/lcd_framer_chk.sv
module lcd_framer_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       start,
   input logic [1:0] mode,
   input logic       busy,
   input logic       done,
   input logic       cs,
   input logic       sclk,
   input logic       sdo
);
   // R6
   sclk_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sclk |-> cs);
   // R6
   sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk && $past(sclk)) |-> $stable(sdo));
   // R8
   done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));
   // R8
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R10
   open_by_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ($past(start) && $past(mode) != 2'd3));
   // R7
   cs_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs) |-> done);
endmodule

bind lcd_serial_framer lcd_framer_chk u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
   .busy(busy), .done(done), .cs(cs), .sclk(sclk), .sdo(sdo)
);

// File: tb/sim_lcd_serial_framer.sv
module sim_lcd_serial_framer;
   localparam int HD = 2;
   localparam int BB = 16;
   localparam int NV = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [1:0] mode = 2'd0;
   logic rw = 1'b0, rs = 1'b0;
   logic [8*BB-1:0] payload = '0;
   logic busy, done, cs, sclk, sdo;

   always #4 clk = ~clk;

   lcd_serial_framer #(.HALF_DIV(HD), .BURST_BYTES(BB)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .rw(rw), .rs(rs),
      .payload(payload), .busy(busy), .done(done), .cs(cs), .sclk(sclk), .sdo(sdo)
   );

   localparam logic [1:0] V_MODE [NV] = '{2'd0, 2'd0, 2'd0, 2'd1, 2'd2};
   localparam logic       V_RW   [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1};
   localparam logic       V_RS   [NV] = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b0};
   localparam logic [127:0] V_PAY [NV] = '{
      128'h30, 128'hA5, 128'hFF0F, 128'h5A_93,
      128'h0F1E2D3C4B5A69788796A5B4C3D2E1F0};

   int tests = 0, fails = 0;
   logic bits [0:16383];
   int nbits = 0, busy_cnt = 0, done_cnt = 0, cs_rise = 0, sclk_bad = 0;
   logic sclk_q = 1'b0, cs_q = 1'b0;

   always @(negedge clk) begin
      if (cs && sclk && !sclk_q) begin
         bits[nbits] = sdo;
         nbits = nbits + 1;
      end
      if (!cs && (sclk || sdo)) sclk_bad = sclk_bad + 1;
      if (busy) busy_cnt = busy_cnt + 1;
      if (done) done_cnt = done_cnt + 1;
      if (cs && !cs_q) cs_rise = cs_rise + 1;
      sclk_q = sclk;
      cs_q = cs;
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   function automatic int nwire(input logic [1:0] m);
      return (m == 2'd0) ? 3 : (m == 2'd1) ? 5 : 1 + 2*BB;
   endfunction

   function automatic logic [7:0] exp_byte(input logic [1:0] m, input logic w,
                                           input logic s, input logic [127:0] p, input int k);
      logic [7:0] b;
      if (k == 0) begin
         if (m == 2'd0)      return 8'hF8 | {5'b0, w, s, 1'b0};
         else if (m == 2'd1) return 8'hF8;
         else                return 8'hFA;
      end
      b = p[8*((k-1)/2) +: 8];
      return ((k-1) % 2 == 0) ? {b[7:4], 4'h0} : {b[3:0], 4'h0};
   endfunction

   task automatic run_frame(input logic [1:0] m, input logic w, input logic s,
                            input logic [127:0] p, input string tag);
      int b0, bc0, dc0, nw, nb, errs;
      logic [7:0] got, exp, bad_g, bad_e;
      nw = nwire(m);
      @(negedge clk);
      b0 = nbits; bc0 = busy_cnt; dc0 = done_cnt;
      mode = m; rw = w; rs = s; payload = p; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (done_cnt == dc0) @(negedge clk);
      repeat (3) @(negedge clk);
      nb = nbits - b0;
      chk(nb == 8*nw, {tag, " bit count"}, nb, 8*nw);
      errs = 0; bad_g = 0; bad_e = 0;
      for (int k = 0; k < nw && 8*k+7 < nb; k++) begin
         got = 0;
         for (int i = 0; i < 8; i++) got = {got[6:0], bits[b0 + 8*k + i]};
         exp = exp_byte(m, w, s, p, k);
         if (got != exp && errs == 0) begin bad_g = got; bad_e = exp; end
         if (got != exp) errs++;
      end
      chk(errs == 0, {tag, " wire bytes R1 R2 R6"}, bad_g, bad_e);
      chk(busy_cnt - bc0 == HD*(16*nw+1), "R8 busy length", busy_cnt - bc0, HD*(16*nw+1));
      chk(done_cnt - dc0 == 1, "R8 done single pulse", done_cnt - dc0, 1);
   endtask

   initial begin
      #(8 * 150000);
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      int rc, bc, b0;
      repeat (3) @(negedge clk);
      // R11 reset state
      chk({cs, sclk, sdo, busy, done} == 5'b0, "R11 reset outputs",
          {cs, sclk, sdo, busy, done}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk({cs, sclk, sdo, busy, done} == 5'b0, "R11 idle after reset",
          {cs, sclk, sdo, busy, done}, 0);

      // R3 R4 R5 table walk
      for (int v = 0; v < NV; v++) begin
         string tag;
         tag = (V_MODE[v] == 2'd0) ? "R3" : (V_MODE[v] == 2'd1) ? "R4" : "R5";
         run_frame(V_MODE[v], V_RW[v], V_RS[v], V_PAY[v], tag);
      end

      // R7 chip select timing: one half period before first rise
      @(negedge clk);
      mode = 2'd0; rw = 0; rs = 0; payload = 128'h81; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(cs == 1'b1 && sclk == 1'b0, "R7 cs high after accept", {cs, sclk}, 2'b10);
      chk(sdo == 1'b1, "R6 first bit MSB of header", sdo, 1);
      repeat (HD) @(negedge clk);
      chk(sclk == 1'b1, "R7 first rise after lead half", sclk, 1);
      while (busy) @(negedge clk);
      repeat (3) @(negedge clk);

      // R9 start while busy ignored
      rc = cs_rise; b0 = nbits;
      @(negedge clk);
      mode = 2'd0; rw = 0; rs = 1; payload = 128'h3C; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (20) @(negedge clk);
      mode = 2'd2; rw = 1; rs = 0; payload = {16{8'hFF}}; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (busy) @(negedge clk);
      repeat (60) @(negedge clk);
      chk(nbits - b0 == 24, "R9 frame length unchanged", nbits - b0, 24);
      begin
         logic [7:0] g;
         g = 0;
         for (int i = 0; i < 8; i++) g = {g[6:0], bits[b0 + 8 + i]};
         chk(g == 8'h30, "R9 payload unchanged", g, 8'h30);
      end
      chk(cs_rise - rc == 1, "R9 no second frame", cs_rise - rc, 1);

      // R10 reserved mode ignored
      rc = cs_rise; bc = busy_cnt; b0 = nbits;
      @(negedge clk);
      mode = 2'd3; payload = 128'hFF; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (40) @(negedge clk);
      chk(busy_cnt == bc && cs_rise == rc && nbits == b0, "R10 reserved mode",
          busy_cnt - bc, 0);

      chk(sclk_bad == 0, "R6 R7 sclk and sdo quiet outside frame", sclk_bad, 0);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule